// File: doc/BRIEF.md
# I2C Serial EEPROM Target Controller

This block is the digital core of a byte-wide serial EEPROM that answers on an I2C bus. SCL and SDA arrive already sampled into the system clock domain. The block drives a single open-drain pull-down enable for SDA. Two strap inputs select which of four bus addresses it answers to, so four parts can share one bus. The word address is 15 bits wide, which gives 32,768 byte locations. The storage is a behavioural register array. Its depth is set by `STORE_AW`: the default of 11 keeps elaboration small, and the upper word-address bits then alias. A full-size build sets `STORE_AW` to 15.

A write names a location and then streams data bytes into a 64-byte page buffer. Nothing reaches the array until the master sends STOP. At STOP the block starts a self-timed write cycle that moves the buffered bytes into the array. While that cycle runs, the block refuses its own bus address. A write-protect input that is high at STOP cancels the commit for the whole array. A read returns the byte at the current address pointer and then advances the pointer. A repeated START after the address bytes gives a random read. A read with no address bytes continues from where the pointer was left.

Top module: `eep_i2c_target`

## Requirements
- R1: After reset, `sda_oe` is low, no transaction is in progress and no write cycle is running.
- R2: The address byte is 1010, then 0, then `dev_sel[1]`, then `dev_sel[0]`, then the read/write bit (1 = read). A byte that does not match is not acknowledged. The block then ignores the bus until the next START.
- R3: `sda_oe` rises only while SCL is low. A bit the block drives stays stable across the whole SCL high phase. Incoming bits are captured on the rising edge of SCL.
- R4: A write sends two word-address bytes, high byte first. Bit 7 of the high byte is ignored, which gives a 15-bit address. Every address byte is acknowledged.
- R5: Data bytes fill a 64-byte page buffer. The offset is the low 6 address bits and it wraps within the page. A later byte to the same offset replaces the earlier one. Every data byte is acknowledged.
- R6: A STOP that follows at least one data byte starts a write cycle of exactly `WR_CYCLES` clocks. The cycle commits every buffered byte to its page.
- R7: While a write cycle runs, `sda_oe` stays low and the block's own address byte is not acknowledged.
- R8: If `wp_i` is high at STOP, the address and data bytes are still acknowledged. No write cycle starts and the array stays unchanged.
- R9: A random read (address bytes, repeated START, read address byte) returns the byte stored at that address.
- R10: Each byte read advances the pointer by one, wrapping from 0x7FFF to 0. A read with no address bytes continues from the pointer.
- R11: A master NACK ends the read. The block releases SDA and waits for STOP or START.
- R12: A write that ends with STOP straight after the address bytes starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA bus level |
| dev_sel | input | 2 | Strap bits compared with address bits 2:1 |
| wp_i | input | 1 | Write protect for the whole array, sampled at STOP |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The block registers each SCL edge once before it acts. `sda_oe` therefore changes one clock after the sampled SCL fall, and a data bit is captured one clock after the sampled rise. The write cycle starts two clocks after the sampled STOP and lasts `WR_CYCLES` clocks. The bench drives inputs on falling clock edges and holds each SCL phase for at least four clocks. It reads acknowledges and data two clocks into the SCL high phase, when every registered update has settled. It probes the address straight after a committing STOP, inside the busy window, and then polls until the address is acknowledged again.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int WORD_AW    = 15;
    localparam int PAGE_AW    = 6;
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam logic [3:0] DEV_ID = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDATA, ST_RDATA
    } bus_st_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(logic [6:0] a, logic [1:0] sel);
        return a == {DEV_ID, 1'b0, sel};
    endfunction

    function automatic logic [WORD_AW-1:0] next_in_page(logic [WORD_AW-1:0] a);
        return {a[WORD_AW-1:PAGE_AW], a[PAGE_AW-1:0] + 1'b1};
    endfunction
endpackage

// File: rtl/eep_bus_events.sv
module eep_bus_events
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
        ev.sda   = sda_i;
    end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [PAGE_AW-1:0] wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [PAGE_AW-1:0] rd_idx,
    output logic [7:0]         rd_data,
    output logic               rd_vld,
    output logic               any_vld
);
    localparam int N = 1 << PAGE_AW;

    logic [7:0]   bytes_q [N];
    logic [N-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx]   <= 1'b1;
            bytes_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = bytes_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
    assign any_vld = |vld_q;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
    parameter int CYCLES  = 250000,
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               busy,
    output logic               step_en,
    output logic [PAGE_AW-1:0] step_idx
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam int PB = 1 << PAGE_AW;

    logic [CW-1:0] cnt;
    logic [CW-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy     = (cnt != '0);
    assign elapsed  = CW'(CYCLES) - cnt;
    assign step_en  = busy && (elapsed < CW'(PB));
    assign step_idx = elapsed[PAGE_AW-1:0];
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
    import eep_pkg::*;
#(
    parameter int STORE_AW  = 11,
    parameter int WR_CYCLES = 250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] dev_sel,
    input  logic       wp_i,
    output logic       sda_oe
);
    localparam int DEPTH = 1 << STORE_AW;
    localparam int PGW   = WORD_AW - PAGE_AW;

    bus_ev_t              ev;
    bus_st_t              state;
    logic [3:0]           bit_idx;
    logic                 ack_ph, rd_req, m_ack;
    logic [7:0]           shreg, tx;
    logic [WORD_AW-1:0]   addr;
    logic [PGW-1:0]       cpage;
    logic [7:0]           mem [DEPTH];
    logic [7:0]           mem_rd;

    logic                 pb_wr, pb_clr, pb_any, pb_rd_vld;
    logic [PAGE_AW-1:0]   pb_idx;
    logic [7:0]           pb_dat, pb_rd_dat;
    logic                 wr_go, wr_busy, step_en;
    logic [PAGE_AW-1:0]   step_idx;
    logic [WORD_AW-1:0]   commit_addr;

    eep_bus_events u_ev (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    eep_page_buf #(.PAGE_AW(PAGE_AW)) u_pbuf (
        .clk(clk), .rst(rst), .clr(pb_clr),
        .wr_en(pb_wr), .wr_idx(pb_idx), .wr_data(pb_dat),
        .rd_idx(step_idx), .rd_data(pb_rd_dat), .rd_vld(pb_rd_vld),
        .any_vld(pb_any)
    );

    eep_wr_timer #(.CYCLES(WR_CYCLES), .PAGE_AW(PAGE_AW)) u_tmr (
        .clk(clk), .rst(rst), .start(wr_go), .busy(wr_busy),
        .step_en(step_en), .step_idx(step_idx)
    );

    assign mem_rd      = mem[addr[STORE_AW-1:0]];
    assign commit_addr = {cpage, step_idx};

    // Self-timed commit: one buffered byte per clock during the busy window
    always_ff @(posedge clk) begin
        if (step_en && pb_rd_vld)
            mem[commit_addr[STORE_AW-1:0]] <= pb_rd_dat;
    end

    always_ff @(posedge clk) begin
        pb_wr  <= 1'b0;
        pb_clr <= 1'b0;
        wr_go  <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            ack_ph  <= 1'b0;
            rd_req  <= 1'b0;
            m_ack   <= 1'b0;
            shreg   <= '0;
            tx      <= '0;
            addr    <= '0;
            cpage   <= '0;
            pb_idx  <= '0;
            pb_dat  <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.stop) begin
            if (state == ST_WDATA && pb_any && !wp_i && !wr_busy) begin
                wr_go <= 1'b1;
                cpage <= addr[WORD_AW-1:PAGE_AW];
            end
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
            ack_ph  <= 1'b0;
            bit_idx <= '0;
        end else if (ev.start) begin
            state   <= ST_DEV;
            sda_oe  <= 1'b0;
            ack_ph  <= 1'b0;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (ev.rise && !ack_ph && bit_idx != 4'd8) begin
                        shreg   <= {shreg[6:0], ev.sda};
                        bit_idx <= bit_idx + 1'b1;
                    end else if (ev.fall && ack_ph) begin
                        ack_ph  <= 1'b0;
                        sda_oe  <= 1'b0;
                        bit_idx <= '0;
                        case (state)
                            ST_DEV: begin
                                if (rd_req) begin
                                    state  <= ST_RDATA;
                                    tx     <= mem_rd;
                                    sda_oe <= ~mem_rd[7];
                                    addr   <= addr + 1'b1;
                                end else begin
                                    state <= ST_AHI;
                                end
                            end
                            ST_AHI:  state <= ST_ALO;
                            ST_ALO:  state <= ST_WDATA;
                            default: state <= ST_WDATA;
                        endcase
                    end else if (ev.fall && bit_idx == 4'd8) begin
                        ack_ph <= 1'b1;
                        case (state)
                            ST_DEV: begin
                                if (dev_match(shreg[7:1], dev_sel) && !wr_busy) begin
                                    sda_oe <= 1'b1;
                                    rd_req <= shreg[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                addr[WORD_AW-1:8] <= shreg[WORD_AW-9:0];
                                sda_oe <= 1'b1;
                            end
                            ST_ALO: begin
                                addr[7:0] <= shreg;
                                pb_clr    <= 1'b1;
                                sda_oe    <= 1'b1;
                            end
                            default: begin
                                pb_wr  <= 1'b1;
                                pb_idx <= addr[PAGE_AW-1:0];
                                pb_dat <= shreg;
                                addr   <= next_in_page(addr);
                                sda_oe <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (ev.rise) begin
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == 4'd8) m_ack <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (bit_idx == 4'd9) begin
                            bit_idx <= '0;
                            if (m_ack) begin
                                tx     <= mem_rd;
                                sda_oe <= ~mem_rd[7];
                                addr   <= addr + 1'b1;
                            end else begin
                                state  <= ST_IDLE;
                                sda_oe <= 1'b0;
                            end
                        end else if (bit_idx == 4'd8) begin
                            sda_oe <= 1'b0;
                        end else if (bit_idx != 4'd0) begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eep_i2c_checker.sv
module eep_i2c_checker #(
    parameter int WR_CYCLES = 250000
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       wp_i,
    input logic       sda_oe,
    input logic       wr_busy,
    input logic [3:0] bit_idx
);
    int busy_len;

    always_ff @(posedge clk) begin
        if (rst)          busy_len <= 0;
        else if (wr_busy) busy_len <= busy_len + 1;
        else              busy_len <= 0;
    end

    // R3: the pull-down is only switched on while SCL is low
    a_r3_drive_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R7: nothing is driven on the bus during a write cycle
    a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        wr_busy |-> !sda_oe);

    // R8: a write cycle never starts when protect was high at STOP
    a_r8_no_cycle_under_wp: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_busy) |-> !$past(wp_i, 2));

    // R6: the write cycle lasts exactly WR_CYCLES clocks
    a_r6_cycle_length: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_busy) |-> busy_len == WR_CYCLES);

    // R2: bit counter never passes the acknowledge slot
    a_r2_bit_bounds: assert property (@(posedge clk) disable iff (rst)
        bit_idx <= 4'd9);
endmodule

bind eep_i2c_target eep_i2c_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .wp_i(wp_i),
    .sda_oe(sda_oe), .wr_busy(wr_busy), .bit_idx(bit_idx)
);

// File: tb/tb_eep_i2c_target.sv
module tb_eep_i2c_target;
    localparam int STORE_AW = 11;
    localparam int WR       = 200;
    localparam logic [7:0] DEV_W = 8'hA4;
    localparam logic [7:0] DEV_R = 8'hA5;

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [1:0] sel = 2'b10;

    assign sda_line = sda_m & ~sda_oe;

    eep_i2c_target #(.STORE_AW(STORE_AW), .WR_CYCLES(WR)) dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .dev_sel(sel), .wp_i(wp), .sda_oe(sda_oe)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    logic [7:0]  refm  [1 << STORE_AW];
    bit          known [1 << STORE_AW];
    logic [14:0] ptr = '0;
    logic [7:0]  wbuf  [80];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int sidx(logic [14:0] a);
        return int'(a[STORE_AW-1:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        sda_m = 1; tick(2); scl_m = 1; tick(4); sda_m = 0; tick(4); scl_m = 0; tick(2);
    endtask

    task automatic i2c_stop;
        sda_m = 0; tick(2); scl_m = 1; tick(4); sda_m = 1; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(2); scl_m = 1; tick(4); scl_m = 0; tick(2);
        end
        sda_m = 1; tick(2); scl_m = 1; tick(2);
        acked = (sda_line == 1'b0);
        tick(2); scl_m = 0; tick(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1; tick(2);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1; tick(2);
            b[i] = sda_line;
            tick(2);
            chk(sda_line == b[i], "R3 bit stable while SCL high", sda_line, b[i]);
            scl_m = 0; tick(4);
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        scl_m = 1; tick(4); scl_m = 0; tick(2); sda_m = 1;
    endtask

    task automatic probe(output bit acked);
        i2c_start; send_byte(DEV_W, acked); i2c_stop;
    endtask

    task automatic wait_ready;
        bit a = 0;
        for (int k = 0; k < 40; k++) begin
            probe(a);
            if (a) break;
            tick(10);
        end
        chk(a, "R6 write cycle ends", a, 1);
    endtask

    task automatic model_write(input logic [14:0] a, input int n, input bit prot);
        logic [7:0] pb [64];
        bit pv [64];
        logic [5:0] o = a[5:0];
        for (int j = 0; j < 64; j++) pv[j] = 0;
        for (int i = 0; i < n; i++) begin
            pb[o] = wbuf[i]; pv[o] = 1; o = o + 1'b1;
        end
        ptr = {a[14:6], o};
        if (prot) return;
        for (int j = 0; j < 64; j++)
            if (pv[j]) begin
                refm[sidx({a[14:6], 6'(j)})]  = pb[j];
                known[sidx({a[14:6], 6'(j)})] = 1;
            end
    endtask

    task automatic do_write(input logic [14:0] a, input int n, input bit topbit);
        bit ak;
        i2c_start;
        send_byte(DEV_W, ak);            chk(ak, "R2 matching address acked", ak, 1);
        send_byte({topbit, a[14:8]}, ak); chk(ak, "R4 high address acked", ak, 1);
        send_byte(a[7:0], ak);           chk(ak, "R4 low address acked", ak, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ak);
            chk(ak, wp ? "R8 data acked under protect" : "R5 data acked", ak, 1);
        end
        i2c_stop;
        model_write(a, n, wp);
        if (n > 0 && !wp) begin
            probe(ak);
            chk(!ak, "R7 no ack during write cycle", ak, 0);
            wait_ready;
        end else begin
            probe(ak);
            chk(ak, n == 0 ? "R12 no cycle after address-only write" :
                             "R8 no cycle under protect", ak, 1);
        end
    endtask

    task automatic read_body(input int n, input string tag);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            if (known[sidx(ptr)])
                chk(b == refm[sidx(ptr)], tag, b, refm[sidx(ptr)]);
            ptr = ptr + 1'b1;
        end
        i2c_stop;
        chk(sda_oe == 1'b0, "R11 SDA released after NACK", sda_oe, 0);
    endtask

    task automatic do_read(input logic [14:0] a, input int n, input string tag);
        bit ak;
        i2c_start;
        send_byte(DEV_W, ak);
        send_byte({1'b0, a[14:8]}, ak);
        send_byte(a[7:0], ak);
        i2c_start;
        send_byte(DEV_R, ak); chk(ak, "R9 read address acked", ak, 1);
        ptr = a;
        read_body(n, tag);
    endtask

    task automatic cur_read(input int n);
        bit ak;
        i2c_start;
        send_byte(DEV_R, ak); chk(ak, "R10 current read acked", ak, 1);
        read_body(n, "R10 current-address read");
    endtask

    initial begin
        bit ak;
        int unsigned r;
        logic [14:0] a;
        int n;
        for (int j = 0; j < (1 << STORE_AW); j++) known[j] = 0;
        r = $urandom(32'h5EED1234);
        tick(5);
        chk(sda_oe == 1'b0, "R1 reset output", sda_oe, 0);
        rst = 0; tick(5);
        chk(sda_oe == 1'b0, "R1 idle after reset", sda_oe, 0);

        // R2: wrong strap code, write and read variants; then byte without START
        i2c_start; send_byte(8'hA2, ak); chk(!ak, "R2 wrong address nack", ak, 0);
        send_byte(DEV_W, ak); chk(!ak, "R2 ignored until START", ak, 0);
        i2c_stop;
        i2c_start; send_byte(8'hA3, ak); chk(!ak, "R2 wrong read address nack", ak, 0);
        i2c_stop;

        // R12: address-only write
        do_write(15'h0040, 0, 1'b0);

        // R4: top bit of high address byte ignored
        for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h30 + i);
        do_write(15'h0123, 10, 1'b1);
        do_read(15'h0123, 10, "R4 readback");

        // R5: 70 bytes from offset 0x30 wrap inside the page and overwrite
        for (int i = 0; i < 70; i++) wbuf[i] = 8'($urandom);
        do_write(15'h0230, 70, 1'b0);
        do_read(15'h0200, 64, "R5 page wrap and overwrite");

        // R8: protected write leaves array alone
        wp = 1;
        for (int i = 0; i < 5; i++) wbuf[i] = 8'hEE;
        do_write(15'h0123, 5, 1'b0);
        wp = 0;
        do_read(15'h0123, 5, "R8 array unchanged");

        // R10: sequential read wraps from 0x7FFF to 0 and current read continues
        wbuf[0] = 8'h5A; do_write(15'h7FFF, 1, 1'b0);
        wbuf[0] = 8'hA5; do_write(15'h0000, 1, 1'b0);
        wbuf[0] = 8'h3C; do_write(15'h0001, 1, 1'b0);
        do_read(15'h7FFF, 2, "R10 wrap to zero");
        cur_read(1);

        // R9: random writes and random reads
        for (int t = 0; t < 8; t++) begin
            a = 15'($urandom);
            n = 1 + int'($urandom % 24);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wp = (t == 5);
            do_write(a, n, 1'b0);
            wp = 0;
            do_read(a, n, "R9 random read");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule